// File: doc/BRIEF.md
# Three-Port Two-Bank Memory Arbiter

This block arbitrates byte-level accesses from three ports onto a memory built from two 256-byte banks and a 16-byte settings area. The first side port reaches only the lower bank, and the second side port reaches only the upper bank. A supervisory port sees both banks as one flat 512-byte space: addresses 0x000–0x0FF fall in the lower bank and 0x100–0x1FF fall in the upper bank. With its select input raised, the supervisory port reaches the settings area instead, and no other port can reach that area.

The settings area holds the following:
- a 7-bit device address for each port, driven out to the serial front ends;
- an enable bit for each side port;
- read-block and write-block bits for each port.

Reads on the two side ports are served in parallel. A write of 1 to 16 bytes stays inside its aligned 16-byte page. After the write is granted, the block stays busy while it stores the bytes and for a parameterised wait interval. During that time every request is refused.

Every request is held until the block answers with a one-cycle accept pulse or a one-cycle refuse pulse. When requests collide, the port that loses simply waits for a later cycle.

Top module: `tri_port_mem_arbiter`

## Requirements
- R1: After reset, no accept or refuse pulse is present. The device-address outputs show the defaults 0x50 (side port 1), 0x51 (side port 2) and 0x52 (supervisory port).
- R2: Supervisory address A with A < 0x100 is the same byte as side-port-1 address A. Supervisory address A with A >= 0x100 is the same byte as side-port-2 address A-0x100. Data written on one path reads back unchanged on the other path.
- R3: Read requests on both side ports that arrive together are both accepted in the same cycle, each with its own bank's data.
- R4: From the write accept until (length+1)+WAIT_CYCLES cycles have passed, every request from any port is refused. Once that time is over, requests are accepted again and the written data is present.
- R5: The length field is the byte count minus 1. Byte i is taken from write-data bits [8i+7:8i] and stored at the page base plus ((start+i) mod 16). Bytes outside the page are untouched.
- R6: The supervisory port wins over side port 1, and side port 1 wins over side port 2. A port that loses waits with no refuse pulse and is accepted in a later cycle.
- R7: Settings byte 3 bit 0 enables side port 1 and bit 1 enables side port 2. A request from a disabled port is refused.
- R8: Settings byte 4 holds the block bits:
  - bit 0: port 1 read-block; bit 1: port 1 write-block;
  - bit 2: port 2 read-block; bit 3: port 2 write-block;
  - bit 4: supervisory bank read-block; bit 5: supervisory bank write-block.

  A blocked request is refused and leaves the memory unchanged. These bits do not apply to settings-area accesses.
- R9: The settings area is written and read only through the supervisory port with its select input raised. Bytes 0, 1 and 2 (bits 6:0) drive the device-address outputs of side port 1, side port 2 and the supervisory port.
- R10: Each answer is exactly one of accept or refuse. It is a single-cycle pulse that appears the cycle after the request is sampled. Read data is valid with the accept pulse.
- R11: A side-port-1 read that meets a side-port-2 write is accepted first. The write waits and is accepted in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| p1_req_i | input | 1 | Side port 1 request, held until answered |
| p1_we_i | input | 1 | Side port 1 write (1) or read (0) |
| p1_addr_i | input | 8 | Side port 1 byte address in the lower bank |
| p1_len_i | input | 4 | Side port 1 write byte count minus 1 |
| p1_wdata_i | input | 128 | Side port 1 page data, byte i at bits 8i+7:8i |
| p1_ack_o | output | 1 | Side port 1 accept pulse |
| p1_nack_o | output | 1 | Side port 1 refuse pulse |
| p1_rdata_o | output | 8 | Side port 1 read data |
| p2_req_i | input | 1 | Side port 2 request |
| p2_we_i | input | 1 | Side port 2 write (1) or read (0) |
| p2_addr_i | input | 8 | Side port 2 byte address in the upper bank |
| p2_len_i | input | 4 | Side port 2 write byte count minus 1 |
| p2_wdata_i | input | 128 | Side port 2 page data |
| p2_ack_o | output | 1 | Side port 2 accept pulse |
| p2_nack_o | output | 1 | Side port 2 refuse pulse |
| p2_rdata_o | output | 8 | Side port 2 read data |
| c_req_i | input | 1 | Supervisory port request |
| c_we_i | input | 1 | Supervisory write (1) or read (0) |
| c_cfg_i | input | 1 | Supervisory target is the settings area |
| c_addr_i | input | 9 | Supervisory flat address (low 4 bits for settings) |
| c_len_i | input | 4 | Supervisory write byte count minus 1 |
| c_wdata_i | input | 128 | Supervisory page data |
| c_ack_o | output | 1 | Supervisory accept pulse |
| c_nack_o | output | 1 | Supervisory refuse pulse |
| c_rdata_o | output | 8 | Supervisory read data |
| p1_dev_addr_o | output | 7 | Device address for side port 1 |
| p2_dev_addr_o | output | 7 | Device address for side port 2 |
| c_dev_addr_o | output | 7 | Device address for the supervisory port |

## Verification
The hardest case is a port that loses arbitration and must wait without being refused. It only occurs when several requests reach the same clock edge while the block is idle.

The bench launches the competing requests in parallel from the same falling edge. It records the cycle in which each port is answered. It then checks that the supervisory port was answered first and that the losers were answered later with an accept.

A read colliding with a write is also driven this way. This confirms that the waiting write is granted on the very next edge, before any busy interval could refuse it.

// File: rtl/tpm_pkg.sv
package tpm_pkg;

    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_PROG = 2'd1,
        PH_WAIT = 2'd2
    } phase_e;

    typedef enum logic [1:0] {
        TGT_B1  = 2'd0,
        TGT_B2  = 2'd1,
        TGT_CFG = 2'd2
    } tgt_e;

    // settings-area byte positions decoded by the arbiter
    localparam int CFG_IDX_P1_DEV = 0;
    localparam int CFG_IDX_P2_DEV = 1;
    localparam int CFG_IDX_C_DEV  = 2;
    localparam int CFG_IDX_ENABLE = 3;
    localparam int CFG_IDX_BLOCK  = 4;

    // port slots inside the arbiter's vectors
    localparam int SLOT_P1 = 0;
    localparam int SLOT_P2 = 1;
    localparam int SLOT_C  = 2;
    localparam int N_SLOTS = 3;

endpackage

// File: rtl/tpm_cfg_store.sv
module tpm_cfg_store #(
    parameter int          AW         = 4,
    parameter int          DEV_AW     = 7,
    parameter logic [6:0]  DEF_P1_DEV = 7'h50,
    parameter logic [6:0]  DEF_P2_DEV = 7'h51,
    parameter logic [6:0]  DEF_C_DEV  = 7'h52
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we_i,
    input  logic [AW-1:0]     widx_i,
    input  logic [7:0]        wdata_i,
    input  logic [AW-1:0]     ridx_i,
    output logic [7:0]        rdata_o,
    output logic [DEV_AW-1:0] p1_dev_o,
    output logic [DEV_AW-1:0] p2_dev_o,
    output logic [DEV_AW-1:0] c_dev_o,
    output logic [1:0]        en_o,
    output logic [5:0]        blk_o
);
    import tpm_pkg::*;

    localparam int DEPTH = 1 << AW;

    logic [7:0] regs_q [DEPTH];
    logic [7:0] regs_d [DEPTH];

    function automatic logic [7:0] reset_byte(input int idx);
        logic [7:0] v;
        case (idx)
            CFG_IDX_P1_DEV: v = {1'b0, DEF_P1_DEV};
            CFG_IDX_P2_DEV: v = {1'b0, DEF_P2_DEV};
            CFG_IDX_C_DEV:  v = {1'b0, DEF_C_DEV};
            CFG_IDX_ENABLE: v = 8'h03;
            default:        v = 8'h00;
        endcase
        return v;
    endfunction

    always_comb begin
        for (int i = 0; i < DEPTH; i++) begin
            regs_d[i] = regs_q[i];
        end
        if (we_i) begin
            regs_d[widx_i] = wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            for (int i = 0; i < DEPTH; i++) begin
                regs_q[i] <= reset_byte(i);
            end
        end else begin
            for (int i = 0; i < DEPTH; i++) begin
                regs_q[i] <= regs_d[i];
            end
        end
    end

    assign rdata_o  = regs_q[ridx_i];
    assign p1_dev_o = regs_q[CFG_IDX_P1_DEV][DEV_AW-1:0];
    assign p2_dev_o = regs_q[CFG_IDX_P2_DEV][DEV_AW-1:0];
    assign c_dev_o  = regs_q[CFG_IDX_C_DEV][DEV_AW-1:0];
    assign en_o     = regs_q[CFG_IDX_ENABLE][1:0];
    assign blk_o    = regs_q[CFG_IDX_BLOCK][5:0];

endmodule

// File: rtl/tpm_bank.sv
module tpm_bank #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          we_i,
    input  logic          re_i,
    input  logic [AW-1:0] addr_i,
    input  logic [7:0]    wdata_i,
    output logic [7:0]    rdata_o
);
    localparam int DEPTH = 1 << AW;

    logic [7:0] mem_q [DEPTH];
    logic [7:0] rdata_q;

    always_ff @(posedge clk) begin
        if (we_i) begin
            mem_q[addr_i] <= wdata_i;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rdata_q <= 8'h00;
        end else if (re_i) begin
            rdata_q <= mem_q[addr_i];
        end
    end

    assign rdata_o = rdata_q;

    // a bank read is only ever granted while no page is being stored (R4)
    assert_no_read_during_store_R4: assert property (
        @(posedge clk) disable iff (!rst_n) !(we_i && re_i)
    );

endmodule

// File: rtl/tpm_port_gate.sv
module tpm_port_gate (
    input  logic req_i,
    input  logic we_i,
    input  logic cfg_i,
    input  logic en_i,
    input  logic rd_blk_i,
    input  logic wr_blk_i,
    input  logic busy_i,
    output logic deny_o,
    output logic ok_o
);
    logic refuse;

    always_comb begin
        refuse = busy_i || (!cfg_i && (!en_i || (we_i ? wr_blk_i : rd_blk_i)));
        deny_o = req_i && refuse;
        ok_o   = req_i && !refuse;
    end

endmodule

// File: rtl/tri_port_mem_arbiter.sv
module tri_port_mem_arbiter #(
    parameter int          BANK_AW     = 8,
    parameter int          PAGE_AW     = 4,
    parameter int          DEV_AW      = 7,
    parameter int          WAIT_CYCLES = 625000,
    parameter logic [6:0]  DEF_P1_DEV  = 7'h50,
    parameter logic [6:0]  DEF_P2_DEV  = 7'h51,
    parameter logic [6:0]  DEF_C_DEV   = 7'h52
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic                     p1_req_i,
    input  logic                     p1_we_i,
    input  logic [BANK_AW-1:0]       p1_addr_i,
    input  logic [PAGE_AW-1:0]       p1_len_i,
    input  logic [(8<<PAGE_AW)-1:0]  p1_wdata_i,
    output logic                     p1_ack_o,
    output logic                     p1_nack_o,
    output logic [7:0]               p1_rdata_o,
    input  logic                     p2_req_i,
    input  logic                     p2_we_i,
    input  logic [BANK_AW-1:0]       p2_addr_i,
    input  logic [PAGE_AW-1:0]       p2_len_i,
    input  logic [(8<<PAGE_AW)-1:0]  p2_wdata_i,
    output logic                     p2_ack_o,
    output logic                     p2_nack_o,
    output logic [7:0]               p2_rdata_o,
    input  logic                     c_req_i,
    input  logic                     c_we_i,
    input  logic                     c_cfg_i,
    input  logic [BANK_AW:0]         c_addr_i,
    input  logic [PAGE_AW-1:0]       c_len_i,
    input  logic [(8<<PAGE_AW)-1:0]  c_wdata_i,
    output logic                     c_ack_o,
    output logic                     c_nack_o,
    output logic [7:0]               c_rdata_o,
    output logic [DEV_AW-1:0]        p1_dev_addr_o,
    output logic [DEV_AW-1:0]        p2_dev_addr_o,
    output logic [DEV_AW-1:0]        c_dev_addr_o
);
    import tpm_pkg::*;

    localparam int PAGE_BYTES = 1 << PAGE_AW;
    localparam int PAGE_BITS  = 8 * PAGE_BYTES;
    localparam int PAGE_HI_W  = BANK_AW - PAGE_AW;
    localparam int WAIT_W     = $clog2(WAIT_CYCLES + 1);
    localparam int N_BANKS    = 2;

    typedef struct packed {
        phase_e                 phase;
        tgt_e                   tgt;
        logic [PAGE_HI_W-1:0]   hi;
        logic [PAGE_AW-1:0]     start;
        logic [PAGE_AW-1:0]     idx;
        logic [PAGE_AW-1:0]     last;
        logic [PAGE_BITS-1:0]   pbuf;
        logic [WAIT_W-1:0]      wcnt;
        logic [N_SLOTS-1:0]     ack;
        logic [N_SLOTS-1:0]     nack;
        tgt_e                   src;
        logic [7:0]             cfg_rd;
    } st_t;

    st_t st_d, st_q;

    // settings area
    logic                 cfg_we;
    logic [PAGE_AW-1:0]   cfg_widx;
    logic [7:0]           cfg_wdata;
    logic [7:0]           cfg_rdata;
    logic [1:0]           cfg_en;
    logic [5:0]           cfg_blk;

    tpm_cfg_store #(
        .AW         (PAGE_AW),
        .DEV_AW     (DEV_AW),
        .DEF_P1_DEV (DEF_P1_DEV),
        .DEF_P2_DEV (DEF_P2_DEV),
        .DEF_C_DEV  (DEF_C_DEV)
    ) u_cfg (
        .clk      (clk),
        .rst_n    (rst_n),
        .we_i     (cfg_we),
        .widx_i   (cfg_widx),
        .wdata_i  (cfg_wdata),
        .ridx_i   (c_addr_i[PAGE_AW-1:0]),
        .rdata_o  (cfg_rdata),
        .p1_dev_o (p1_dev_addr_o),
        .p2_dev_o (p2_dev_addr_o),
        .c_dev_o  (c_dev_addr_o),
        .en_o     (cfg_en),
        .blk_o    (cfg_blk)
    );

    // per-port admission
    logic               busy;
    logic [N_SLOTS-1:0] req_v, we_v, cfg_v, en_v, rblk_v, wblk_v, deny_v, ok_v;

    assign busy   = (st_q.phase != PH_IDLE);
    assign req_v  = {c_req_i, p2_req_i, p1_req_i};
    assign we_v   = {c_we_i,  p2_we_i,  p1_we_i};
    assign cfg_v  = {c_cfg_i, 1'b0, 1'b0};
    assign en_v   = {1'b1, cfg_en[1], cfg_en[0]};
    assign rblk_v = {cfg_blk[4], cfg_blk[2], cfg_blk[0]};
    assign wblk_v = {cfg_blk[5], cfg_blk[3], cfg_blk[1]};

    for (genvar s = 0; s < N_SLOTS; s++) begin : g_gate
        tpm_port_gate u_gate (
            .req_i    (req_v[s]),
            .we_i     (we_v[s]),
            .cfg_i    (cfg_v[s]),
            .en_i     (en_v[s]),
            .rd_blk_i (rblk_v[s]),
            .wr_blk_i (wblk_v[s]),
            .busy_i   (busy),
            .deny_o   (deny_v[s]),
            .ok_o     (ok_v[s])
        );
    end

    // banks
    logic [N_BANKS-1:0] bk_we, bk_re;
    logic [BANK_AW-1:0] bk_addr  [N_BANKS];
    logic [7:0]         bk_rdata [N_BANKS];
    logic [7:0]         bk_wdata;

    for (genvar b = 0; b < N_BANKS; b++) begin : g_bank
        tpm_bank #(.AW(BANK_AW)) u_bank (
            .clk     (clk),
            .rst_n   (rst_n),
            .we_i    (bk_we[b]),
            .re_i    (bk_re[b]),
            .addr_i  (bk_addr[b]),
            .wdata_i (bk_wdata),
            .rdata_o (bk_rdata[b])
        );
    end

    // next-state computation
    logic               g_c, g_1, g_2, c_hi_bank;
    logic [PAGE_AW-1:0] wr_lo;
    logic [7:0]         cur_byte;
    logic [BANK_AW-1:0] wr_addr;

    always_comb begin
        st_d      = st_q;
        st_d.ack  = '0;
        st_d.nack = deny_v;

        c_hi_bank = c_addr_i[BANK_AW];
        wr_lo     = st_q.start + st_q.idx;
        cur_byte  = st_q.pbuf[{st_q.idx, 3'b000} +: 8];
        wr_addr   = {st_q.hi, wr_lo};

        // supervisory first, then side port 1; a write holds both banks
        g_c = ok_v[SLOT_C];
        g_1 = ok_v[SLOT_P1] && !g_c;
        g_2 = ok_v[SLOT_P2] && !g_c && !(ok_v[SLOT_P1] && (p1_we_i || p2_we_i));
        st_d.ack = {g_c, g_2, g_1};

        bk_re[0]   = (g_1 && !p1_we_i) || (g_c && !c_we_i && !c_cfg_i && !c_hi_bank);
        bk_re[1]   = (g_2 && !p2_we_i) || (g_c && !c_we_i && !c_cfg_i &&  c_hi_bank);
        bk_we[0]   = (st_q.phase == PH_PROG) && (st_q.tgt == TGT_B1);
        bk_we[1]   = (st_q.phase == PH_PROG) && (st_q.tgt == TGT_B2);
        bk_addr[0] = busy ? wr_addr : (g_c ? c_addr_i[BANK_AW-1:0] : p1_addr_i);
        bk_addr[1] = busy ? wr_addr : (g_c ? c_addr_i[BANK_AW-1:0] : p2_addr_i);
        bk_wdata   = cur_byte;

        cfg_we    = (st_q.phase == PH_PROG) && (st_q.tgt == TGT_CFG);
        cfg_widx  = wr_lo;
        cfg_wdata = cur_byte;

        unique case (st_q.phase)
            PH_IDLE: begin
                if (g_c && !c_we_i) begin
                    st_d.src = c_cfg_i ? TGT_CFG : (c_hi_bank ? TGT_B2 : TGT_B1);
                    if (c_cfg_i) begin
                        st_d.cfg_rd = cfg_rdata;
                    end
                end
                if (g_c && c_we_i) begin
                    st_d.phase = PH_PROG;
                    st_d.tgt   = c_cfg_i ? TGT_CFG : (c_hi_bank ? TGT_B2 : TGT_B1);
                    st_d.hi    = c_addr_i[BANK_AW-1:PAGE_AW];
                    st_d.start = c_addr_i[PAGE_AW-1:0];
                    st_d.last  = c_len_i;
                    st_d.pbuf  = c_wdata_i;
                    st_d.idx   = '0;
                end else if (g_1 && p1_we_i) begin
                    st_d.phase = PH_PROG;
                    st_d.tgt   = TGT_B1;
                    st_d.hi    = p1_addr_i[BANK_AW-1:PAGE_AW];
                    st_d.start = p1_addr_i[PAGE_AW-1:0];
                    st_d.last  = p1_len_i;
                    st_d.pbuf  = p1_wdata_i;
                    st_d.idx   = '0;
                end else if (g_2 && p2_we_i) begin
                    st_d.phase = PH_PROG;
                    st_d.tgt   = TGT_B2;
                    st_d.hi    = p2_addr_i[BANK_AW-1:PAGE_AW];
                    st_d.start = p2_addr_i[PAGE_AW-1:0];
                    st_d.last  = p2_len_i;
                    st_d.pbuf  = p2_wdata_i;
                    st_d.idx   = '0;
                end
            end
            PH_PROG: begin
                if (st_q.idx == st_q.last) begin
                    st_d.phase = PH_WAIT;
                    st_d.wcnt  = WAIT_W'(WAIT_CYCLES - 1);
                end else begin
                    st_d.idx = st_q.idx + 1'b1;
                end
            end
            PH_WAIT: begin
                if (st_q.wcnt == '0) begin
                    st_d.phase = PH_IDLE;
                end else begin
                    st_d.wcnt = st_q.wcnt - 1'b1;
                end
            end
            default: st_d.phase = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q <= '0;
        end else begin
            st_q <= st_d;
        end
    end

    assign p1_ack_o  = st_q.ack[SLOT_P1];
    assign p2_ack_o  = st_q.ack[SLOT_P2];
    assign c_ack_o   = st_q.ack[SLOT_C];
    assign p1_nack_o = st_q.nack[SLOT_P1];
    assign p2_nack_o = st_q.nack[SLOT_P2];
    assign c_nack_o  = st_q.nack[SLOT_C];
    assign p1_rdata_o = bk_rdata[0];
    assign p2_rdata_o = bk_rdata[1];

    always_comb begin
        unique case (st_q.src)
            TGT_B1:  c_rdata_o = bk_rdata[0];
            TGT_B2:  c_rdata_o = bk_rdata[1];
            default: c_rdata_o = st_q.cfg_rd;
        endcase
    end

    // assertions
    assert_resp_exclusive_R10: assert property (
        @(posedge clk) disable iff (!rst_n) (st_q.ack & st_q.nack) == '0
    );

    assert_busy_refuses_R4: assert property (
        @(posedge clk) disable iff (!rst_n) (st_q.phase != PH_IDLE) |=> (st_q.ack == '0)
    );

    assert_ctrl_alone_R6: assert property (
        @(posedge clk) disable iff (!rst_n) st_q.ack[SLOT_C] |-> (st_q.ack[SLOT_P2:SLOT_P1] == 2'b00)
    );

    assert_dual_grant_reads_R3: assert property (
        @(posedge clk) disable iff (!rst_n)
            (st_q.ack[SLOT_P1] && st_q.ack[SLOT_P2]) |-> (st_q.phase == PH_IDLE)
    );

    assert_store_ends_R5: assert property (
        @(posedge clk) disable iff (!rst_n)
            (st_q.phase == PH_PROG) |=> (st_q.phase == PH_PROG || st_q.phase == PH_WAIT)
    );

endmodule

// File: tb/tri_port_mem_arbiter_tb.sv
module tri_port_mem_arbiter_tb_top;

    localparam int WAITC = 20;
    localparam int SETTLE = 16 + WAITC + 6;

    typedef struct {
        bit         exp_ack;
        bit         chk_data;
        logic [7:0] data;
        string      tag;
    } exp_t;

    logic         clk = 1'b0;
    logic         rst_n = 1'b0;
    logic         req [3];
    logic         we [3];
    logic         csel;
    logic [8:0]   addr [3];
    logic [3:0]   len [3];
    logic [127:0] wdat [3];
    logic         ack [3];
    logic         nack [3];
    logic [7:0]   rdat [3];
    logic [6:0]   dev1, dev2, devc;

    exp_t sbq [3][$];
    int   resp_cyc [3];
    int   cyc = 0;
    int   n_tests = 0;
    int   n_fail = 0;
    bit   done = 1'b0;

    always #4 clk = ~clk;

    tri_port_mem_arbiter #(.WAIT_CYCLES(WAITC)) dut_i (
        .clk           (clk),
        .rst_n         (rst_n),
        .p1_req_i      (req[0]),
        .p1_we_i       (we[0]),
        .p1_addr_i     (addr[0][7:0]),
        .p1_len_i      (len[0]),
        .p1_wdata_i    (wdat[0]),
        .p1_ack_o      (ack[0]),
        .p1_nack_o     (nack[0]),
        .p1_rdata_o    (rdat[0]),
        .p2_req_i      (req[1]),
        .p2_we_i       (we[1]),
        .p2_addr_i     (addr[1][7:0]),
        .p2_len_i      (len[1]),
        .p2_wdata_i    (wdat[1]),
        .p2_ack_o      (ack[1]),
        .p2_nack_o     (nack[1]),
        .p2_rdata_o    (rdat[1]),
        .c_req_i       (req[2]),
        .c_we_i        (we[2]),
        .c_cfg_i       (csel),
        .c_addr_i      (addr[2]),
        .c_len_i       (len[2]),
        .c_wdata_i     (wdat[2]),
        .c_ack_o       (ack[2]),
        .c_nack_o      (nack[2]),
        .c_rdata_o     (rdat[2]),
        .p1_dev_addr_o (dev1),
        .p2_dev_addr_o (dev2),
        .c_dev_addr_o  (devc)
    );

    task automatic check(input bit ok, input string tag, input string what,
                         input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s %s actual=%0h expected=%0h", tag, what, act, exp);
        end
    endtask

    // monitor: pops the expected answer for a port when it responds
    always @(negedge clk) begin
        cyc++;
        if (rst_n) begin
            for (int p = 0; p < 3; p++) begin
                if (ack[p] || nack[p]) begin
                    resp_cyc[p] = cyc;
                    check(!(ack[p] && nack[p]), "R10", "accept and refuse together",
                          {ack[p], nack[p]}, 32'h0);
                    if (sbq[p].size() == 0) begin
                        check(1'b0, "R10", "unexpected answer", p, 32'hFF);
                    end else begin
                        exp_t e;
                        e = sbq[p].pop_front();
                        check(ack[p] == e.exp_ack, e.tag, "accept", ack[p], e.exp_ack);
                        if (e.chk_data && ack[p]) begin
                            check(rdat[p] == e.data, e.tag, "read data", rdat[p], e.data);
                        end
                    end
                end
            end
        end
    end

    // driver: pushes the expectation, holds the request until answered
    task automatic access(input int p, input bit w, input bit c, input logic [8:0] a,
                          input logic [3:0] l, input logic [127:0] d,
                          input bit exp_ack, input bit chk, input logic [7:0] ed,
                          input string tag);
        exp_t e;
        e.exp_ack = exp_ack; e.chk_data = chk; e.data = ed; e.tag = tag;
        sbq[p].push_back(e);
        req[p] = 1'b1; we[p] = w; addr[p] = a; len[p] = l; wdat[p] = d;
        if (p == 2) csel = c;
        @(negedge clk);
        while (!(ack[p] || nack[p])) @(negedge clk);
        req[p] = 1'b0;
        @(negedge clk);
        check(!ack[p] && !nack[p], "R10", "answer lasts one cycle", {ack[p], nack[p]}, 32'h0);
        if (p == 2) csel = 1'b0;
    endtask

    task automatic rd(input int p, input logic [8:0] a, input logic [7:0] ed, input string tag);
        access(p, 1'b0, 1'b0, a, 4'd0, 128'h0, 1'b1, 1'b1, ed, tag);
    endtask

    task automatic settle(input int n);
        repeat (n) @(negedge clk);
    endtask

    initial begin
        for (int p = 0; p < 3; p++) begin
            req[p] = 1'b0; we[p] = 1'b0; addr[p] = '0; len[p] = '0; wdat[p] = '0;
        end
        csel = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        // R1: reset state
        check(!ack[0] && !ack[1] && !ack[2] && !nack[0] && !nack[1] && !nack[2],
              "R1", "no answer after reset", 0, 0);
        check(dev1 == 7'h50, "R1", "port1 device address", dev1, 7'h50);
        check(dev2 == 7'h51, "R1", "port2 device address", dev2, 7'h51);
        check(devc == 7'h52, "R1", "ctrl device address", devc, 7'h52);

        // R2 R5: supervisory page into lower bank, read via side port 1
        access(2, 1'b1, 1'b0, 9'h010, 4'd3, 128'hDDCCBBAA, 1'b1, 1'b0, 8'h0, "R5");
        settle(SETTLE);
        rd(0, 9'h010, 8'hAA, "R2");
        rd(0, 9'h011, 8'hBB, "R5");
        rd(0, 9'h012, 8'hCC, "R5");
        rd(0, 9'h013, 8'hDD, "R5");

        // R2: side port 2 write seen at supervisory 0x120
        access(1, 1'b1, 1'b0, 9'h020, 4'd0, 128'h5A, 1'b1, 1'b0, 8'h0, "R2");
        settle(SETTLE);
        rd(2, 9'h120, 8'h5A, "R2");

        // R5: page wrap in upper bank
        access(2, 1'b1, 1'b0, 9'h11E, 4'd3, 128'h44332211, 1'b1, 1'b0, 8'h0, "R5");
        settle(SETTLE);
        rd(1, 9'h01E, 8'h11, "R5");
        rd(1, 9'h01F, 8'h22, "R5");
        rd(1, 9'h010, 8'h33, "R5");
        rd(1, 9'h011, 8'h44, "R5");
        rd(1, 9'h020, 8'h5A, "R5");

        // R4: busy refuses everyone, then releases
        access(0, 1'b1, 1'b0, 9'h030, 4'd0, 128'h77, 1'b1, 1'b0, 8'h0, "R4");
        access(1, 1'b0, 1'b0, 9'h010, 4'd0, 128'h0, 1'b0, 1'b0, 8'h0, "R4");
        access(2, 1'b0, 1'b0, 9'h010, 4'd0, 128'h0, 1'b0, 1'b0, 8'h0, "R4");
        settle(SETTLE);
        rd(0, 9'h030, 8'h77, "R4");

        // R3: parallel side reads
        fork
            begin rd(0, 9'h010, 8'hAA, "R3"); end
            begin rd(1, 9'h010, 8'h33, "R3"); end
        join
        check(resp_cyc[0] == resp_cyc[1], "R3", "same-cycle accept", resp_cyc[0], resp_cyc[1]);

        // R6: supervisory first, losers wait without refusal
        fork
            begin rd(2, 9'h111, 8'h44, "R6"); end
            begin rd(0, 9'h011, 8'hBB, "R6"); end
            begin rd(1, 9'h011, 8'h44, "R6"); end
        join
        check(resp_cyc[2] < resp_cyc[0], "R6", "ctrl before port1", resp_cyc[2], resp_cyc[0]);
        check(resp_cyc[0] == resp_cyc[1], "R6", "waiting reads together", resp_cyc[0], resp_cyc[1]);

        // R11: port1 read beats port2 write
        fork
            begin rd(0, 9'h012, 8'hCC, "R11"); end
            begin access(1, 1'b1, 1'b0, 9'h040, 4'd0, 128'h99, 1'b1, 1'b0, 8'h0, "R11"); end
        join
        check(resp_cyc[0] < resp_cyc[1], "R11", "read accepted first", resp_cyc[0], resp_cyc[1]);
        check(resp_cyc[1] == resp_cyc[0] + 1, "R11", "write next cycle", resp_cyc[1], resp_cyc[0] + 1);
        settle(SETTLE);
        rd(2, 9'h140, 8'h99, "R11");

        // R7: enables
        access(2, 1'b1, 1'b1, 9'h003, 4'd0, 128'h02, 1'b1, 1'b0, 8'h0, "R7");
        settle(SETTLE);
        access(0, 1'b0, 1'b0, 9'h010, 4'd0, 128'h0, 1'b0, 1'b0, 8'h0, "R7");
        rd(1, 9'h010, 8'h33, "R7");
        access(2, 1'b1, 1'b1, 9'h003, 4'd0, 128'h03, 1'b1, 1'b0, 8'h0, "R7");
        settle(SETTLE);
        rd(0, 9'h010, 8'hAA, "R7");

        // R8: block bits
        access(2, 1'b1, 1'b1, 9'h004, 4'd0, 128'h08, 1'b1, 1'b0, 8'h0, "R8");
        settle(SETTLE);
        access(1, 1'b1, 1'b0, 9'h01E, 4'd0, 128'hEE, 1'b0, 1'b0, 8'h0, "R8");
        rd(1, 9'h01E, 8'h11, "R8");
        access(2, 1'b1, 1'b0, 9'h11E, 4'd0, 128'hF0, 1'b1, 1'b0, 8'h0, "R8");
        settle(SETTLE);
        rd(1, 9'h01E, 8'hF0, "R8");
        access(2, 1'b1, 1'b1, 9'h004, 4'd0, 128'h10, 1'b1, 1'b0, 8'h0, "R8");
        settle(SETTLE);
        access(2, 1'b0, 1'b0, 9'h010, 4'd0, 128'h0, 1'b0, 1'b0, 8'h0, "R8");
        access(2, 1'b0, 1'b1, 9'h004, 4'd0, 128'h0, 1'b1, 1'b1, 8'h10, "R9");
        rd(0, 9'h010, 8'hAA, "R8");
        access(2, 1'b1, 1'b1, 9'h004, 4'd0, 128'h00, 1'b1, 1'b0, 8'h0, "R8");
        settle(SETTLE);
        rd(2, 9'h010, 8'hAA, "R8");

        // R9: device addresses through a settings page write
        access(2, 1'b1, 1'b1, 9'h000, 4'd2, 128'h232221, 1'b1, 1'b0, 8'h0, "R9");
        settle(SETTLE);
        check(dev1 == 7'h21, "R9", "port1 device address", dev1, 7'h21);
        check(dev2 == 7'h22, "R9", "port2 device address", dev2, 7'h22);
        check(devc == 7'h23, "R9", "ctrl device address", devc, 7'h23);
        access(2, 1'b0, 1'b1, 9'h001, 4'd0, 128'h0, 1'b1, 1'b1, 8'h22, "R9");

        settle(4);
        for (int p = 0; p < 3; p++) begin
            check(sbq[p].size() == 0, "R10", "answers outstanding", sbq[p].size(), 0);
        end
        done = 1'b1;
        $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        if (!done) begin
            n_tests++;
            n_fail++;
            $display("FAIL watchdog expired actual=hung expected=finished");
            $display("  [TB] %0d tests run, %0d failed", n_tests, n_fail);
            $finish;
        end
    end

endmodule